// File: doc/BRIEF.md
# Tag CAM with Recency Ordering

This block is a sixteen-entry content-addressable store. Each slot holds a 32-bit tag together with four bits of software-defined state. The block also keeps a complete recency ordering across the slots. A caller sends one command per cycle on a small command bus. The command is either a search, a full slot write, a state-only write, a tag readback, a state readback or a wipe. The result comes back on the cycle after the command is taken.

A search compares the presented value against every tag at once and returns a status word. The word holds the slot number, a hit flag and, on a hit, that slot's state. When no tag matches, the slot number is the least recently used slot, so the caller can use it directly as a replacement choice. A search can also produce a local-memory block address. That address is built from the resulting slot number and a two-bit bank field supplied with the search.

Only hits and full writes change the recency order. Misses, state-only writes and readbacks leave it alone. The storage is deliberately left out of the general reset, so software must issue a wipe before first use.

Top module: `tag_cam`

## Requirements
- R1: A full slot write (cmdOp = 1) stores cmdData as the tag and cmdState as the state of slot cmdEntry. Later readbacks of that slot return both values.
- R2: A search (cmdOp = 0) returns a word with the state in bits [11:8], the hit flag in bit 7 and the slot number in bits [6:3]. Bits [31:12] and [2:0] are zero.
- R3: On a search miss, bit 7 is 0, bits [11:8] are 0000, and bits [6:3] name the least recently used slot.
- R4: On a search hit, bit 7 is 1, bits [6:3] name the matching slot, and bits [11:8] carry that slot's stored state.
- R5: A search hit or a full slot write makes that slot the most recently used. A search miss leaves the order unchanged.
- R6: A state-only write (cmdOp = 2) replaces the state of slot cmdEntry. It leaves that slot's tag and the recency order unchanged.
- R7: A tag readback (cmdOp = 3) returns the full 32-bit tag. A state readback (cmdOp = 4) returns the state in bits [11:8] with all other bits zero. Neither readback changes the recency order.
- R8: A wipe (cmdOp = 5) sets every tag and every state to zero. It also resets the order so that slot 0 is least recent and slot 15 is most recent.
- R9: A search issued with cmdLmEn = 1 raises lmAddrValid together with its response. lmAddr then has bits [5:0] = 0, bits [9:6] = the result slot number and bits [11:10] = cmdBank.
- R10: Reset (rstN = 0) clears rspValid, rspData, lmAddrValid and lmAddr. Reset leaves the stored tags, states and recency order untouched.
- R11: Responses appear exactly one cycle after the command is accepted. rspValid is high only for searches and readbacks; full writes, state-only writes and wipes do not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset of the response outputs only |
| cmdValid | input | 1 | Command present this cycle |
| cmdOp | input | 3 | Command code: 0 search, 1 full write, 2 state write, 3 tag read, 4 state read, 5 wipe |
| cmdEntry | input | 4 | Target slot for writes and readbacks |
| cmdData | input | 32 | Search value or tag to store |
| cmdState | input | 4 | State bits for writes |
| cmdLmEn | input | 1 | Request a local-memory address from a search |
| cmdBank | input | 2 | Bank field placed in the address top bits |
| rspValid | output | 1 | Response word valid |
| rspData | output | 32 | Search status or readback value |
| lmAddrValid | output | 1 | Derived address updated |
| lmAddr | output | 12 | Derived local-memory block address |

## Verification
The properties assume that the command inputs are quiet while reset is held. They also assume that no two slots ever hold the same nonzero tag. The stimulus keeps to both rules. Every write of a tag first checks that the tag is not already stored in a different slot, and turns into a state-only write when it is. The stimulus never searches for zero, which is the only value that can repeat after a wipe, and it drops the command inputs before each reset pulse.

// File: rtl/tag_cam_pkg.sv
package tag_cam_pkg;

  typedef enum logic [2:0] {
    OP_LOOKUP   = 3'd0,
    OP_WRITE    = 3'd1,
    OP_WR_STATE = 3'd2,
    OP_RD_TAG   = 3'd3,
    OP_RD_STATE = 3'd4,
    OP_CLEAR    = 3'd5
  } camOp_e;

  typedef struct packed {
    logic lookup;
    logic writeEntry;
    logic writeState;
    logic readTag;
    logic readState;
    logic clear;
    logic lmLoad;
  } camStrobe_t;

endpackage

// File: rtl/tag_cam_ctrl.sv
module tag_cam_ctrl
  import tag_cam_pkg::*;
(
  input  logic       cmdValid,
  input  logic [2:0] cmdOp,
  input  logic       cmdLmEn,
  output camStrobe_t strobe
);

  always_comb begin
    strobe = '0;
    if (cmdValid) begin
      unique case (cmdOp)
        OP_LOOKUP:   begin
          strobe.lookup = 1'b1;
          strobe.lmLoad = cmdLmEn;
        end
        OP_WRITE:    strobe.writeEntry = 1'b1;
        OP_WR_STATE: strobe.writeState = 1'b1;
        OP_RD_TAG:   strobe.readTag    = 1'b1;
        OP_RD_STATE: strobe.readState  = 1'b1;
        OP_CLEAR:    strobe.clear      = 1'b1;
        default:     strobe = '0;
      endcase
    end
  end

endmodule

// File: rtl/tag_cam_dp.sv
module tag_cam_dp
  import tag_cam_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 32,
  parameter int STATE_W = 4,
  parameter int BANK_W  = 2,
  parameter int IDX_W   = $clog2(ENTRIES),
  parameter int LM_W    = 6 + IDX_W + BANK_W
)(
  input  logic               clk,
  input  logic               rstN,
  input  camStrobe_t         strobe,
  input  logic [IDX_W-1:0]   cmdEntry,
  input  logic [TAG_W-1:0]   cmdData,
  input  logic [STATE_W-1:0] cmdState,
  input  logic [BANK_W-1:0]  cmdBank,
  output logic               rspValid,
  output logic [TAG_W-1:0]   rspData,
  output logic               lmAddrValid,
  output logic [LM_W-1:0]    lmAddr
);

  localparam int ENTRY_LSB = 3;
  localparam int HIT_BIT   = ENTRY_LSB + IDX_W;
  localparam int STATE_LSB = HIT_BIT + 1;
  localparam int LM_OFS    = 6;

  logic [TAG_W-1:0]   tagMem   [ENTRIES];
  logic [STATE_W-1:0] stateMem [ENTRIES];
  logic [IDX_W-1:0]   rankMem  [ENTRIES];

  logic [ENTRIES-1:0] hitVec;
  logic               hitAny;
  logic [IDX_W-1:0]   hitIdx;
  logic [IDX_W-1:0]   lruIdx;
  logic [IDX_W-1:0]   resIdx;
  logic               doPromote;
  logic [IDX_W-1:0]   promIdx;
  logic [IDX_W-1:0]   promRank;
  logic [TAG_W-1:0]   lookupWord;
  logic [TAG_W-1:0]   stateWord;

  // parallel compare
  for (genvar g = 0; g < ENTRIES; g++) begin : g_match
    assign hitVec[g] = (tagMem[g] == cmdData);
  end

  assign hitAny = |hitVec;

  always_comb begin
    hitIdx = '0;
    lruIdx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hitVec[i])        hitIdx = IDX_W'(i);
      if (rankMem[i] == '0) lruIdx = IDX_W'(i);
    end
  end

  assign resIdx    = hitAny ? hitIdx : lruIdx;
  assign doPromote = (strobe.lookup && hitAny) || strobe.writeEntry;
  assign promIdx   = strobe.lookup ? hitIdx : cmdEntry;
  assign promRank  = rankMem[promIdx];

  always_comb begin
    lookupWord = '0;
    lookupWord[ENTRY_LSB +: IDX_W] = resIdx;
    lookupWord[HIT_BIT]            = hitAny;
    lookupWord[STATE_LSB +: STATE_W] = hitAny ? stateMem[hitIdx] : '0;
    stateWord = '0;
    stateWord[STATE_LSB +: STATE_W] = stateMem[cmdEntry];
  end

  // storage and recency ranks: deliberately outside reset
  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      for (int i = 0; i < ENTRIES; i++) begin
        tagMem[i]   <= '0;
        stateMem[i] <= '0;
        rankMem[i]  <= IDX_W'(i);
      end
    end else begin
      if (strobe.writeEntry) begin
        tagMem[cmdEntry]   <= cmdData;
        stateMem[cmdEntry] <= cmdState;
      end
      if (strobe.writeState) stateMem[cmdEntry] <= cmdState;
      if (doPromote) begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (IDX_W'(i) == promIdx)     rankMem[i] <= '1;
          else if (rankMem[i] > promRank) rankMem[i] <= rankMem[i] - 1'b1;
        end
      end
    end
  end

  // registered response
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid    <= 1'b0;
      rspData     <= '0;
      lmAddrValid <= 1'b0;
      lmAddr      <= '0;
    end else begin
      rspValid    <= strobe.lookup | strobe.readTag | strobe.readState;
      lmAddrValid <= strobe.lmLoad;
      if (strobe.lookup)         rspData <= lookupWord;
      else if (strobe.readTag)   rspData <= tagMem[cmdEntry];
      else if (strobe.readState) rspData <= stateWord;
      if (strobe.lmLoad) lmAddr <= {cmdBank, resIdx, LM_OFS'(0)};
    end
  end

endmodule

// File: rtl/tag_cam.sv
module tag_cam
  import tag_cam_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 32,
  parameter int STATE_W = 4,
  parameter int BANK_W  = 2,
  parameter int IDX_W   = $clog2(ENTRIES),
  parameter int LM_W    = 6 + IDX_W + BANK_W
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdValid,
  input  logic [2:0]         cmdOp,
  input  logic [IDX_W-1:0]   cmdEntry,
  input  logic [TAG_W-1:0]   cmdData,
  input  logic [STATE_W-1:0] cmdState,
  input  logic               cmdLmEn,
  input  logic [BANK_W-1:0]  cmdBank,
  output logic               rspValid,
  output logic [TAG_W-1:0]   rspData,
  output logic               lmAddrValid,
  output logic [LM_W-1:0]    lmAddr
);

  camStrobe_t strobe;

  tag_cam_ctrl u_ctrl (
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .cmdLmEn  (cmdLmEn),
    .strobe   (strobe)
  );

  tag_cam_dp #(
    .ENTRIES (ENTRIES),
    .TAG_W   (TAG_W),
    .STATE_W (STATE_W),
    .BANK_W  (BANK_W),
    .IDX_W   (IDX_W),
    .LM_W    (LM_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .cmdEntry    (cmdEntry),
    .cmdData     (cmdData),
    .cmdState    (cmdState),
    .cmdBank     (cmdBank),
    .rspValid    (rspValid),
    .rspData     (rspData),
    .lmAddrValid (lmAddrValid),
    .lmAddr      (lmAddr)
  );

endmodule

// File: rtl/tag_cam_chk.sv
module tag_cam_chk #(
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 32,
  parameter int STATE_W = 4,
  parameter int BANK_W  = 2,
  parameter int IDX_W   = $clog2(ENTRIES),
  parameter int LM_W    = 6 + IDX_W + BANK_W
)(
  input logic               clk,
  input logic               rstN,
  input logic               cmdValid,
  input logic [2:0]         cmdOp,
  input logic [IDX_W-1:0]   cmdEntry,
  input logic [TAG_W-1:0]   cmdData,
  input logic [STATE_W-1:0] cmdState,
  input logic               cmdLmEn,
  input logic [BANK_W-1:0]  cmdBank,
  input logic               rspValid,
  input logic [TAG_W-1:0]   rspData,
  input logic               lmAddrValid,
  input logic [LM_W-1:0]    lmAddr
);

  localparam int HIT_BIT   = 3 + IDX_W;
  localparam int STATE_LSB = HIT_BIT + 1;
  localparam logic [TAG_W-1:0] LOOKUP_MASK =
    ~(((TAG_W'(1) << (STATE_W + 1 + IDX_W)) - 1) << 3);
  localparam logic [TAG_W-1:0] RDSTATE_MASK =
    ~(((TAG_W'(1) << STATE_W) - 1) << STATE_LSB);

  logic isLookup, isRead, isRdState;
  assign isLookup  = cmdValid && (cmdOp == 3'd0);
  assign isRdState = cmdValid && (cmdOp == 3'd4);
  assign isRead    = cmdValid && ((cmdOp == 3'd3) || (cmdOp == 3'd4));

  p_latency_r11: assert property (@(posedge clk) disable iff (!rstN)
    rspValid == $past(isLookup || isRead));

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    $past(isLookup) |-> ((rspData & LOOKUP_MASK) == '0));

  p_miss_state_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(isLookup) && !rspData[HIT_BIT]) |-> (rspData[STATE_LSB +: STATE_W] == '0));

  p_rdstate_fmt_r7: assert property (@(posedge clk) disable iff (!rstN)
    $past(isRdState) |-> ((rspData & RDSTATE_MASK) == '0));

  p_lm_addr_r9: assert property (@(posedge clk) disable iff (!rstN)
    lmAddrValid |-> (lmAddr[5:0] == '0 && lmAddr[6 +: IDX_W] == rspData[3 +: IDX_W]
                     && lmAddr[6 + IDX_W +: BANK_W] == $past(cmdBank)));

  p_lm_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    lmAddrValid == $past(isLookup && cmdLmEn));

endmodule

bind tag_cam tag_cam_chk #(
  .ENTRIES (ENTRIES), .TAG_W (TAG_W), .STATE_W (STATE_W),
  .BANK_W (BANK_W), .IDX_W (IDX_W), .LM_W (LM_W)
) u_chk (.*);

// File: tb/tag_cam_tb.sv
module tag_cam_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [2:0]  cmdOp = '0;
  logic [3:0]  cmdEntry = '0;
  logic [31:0] cmdData = '0;
  logic [3:0]  cmdState = '0;
  logic        cmdLmEn = 1'b0;
  logic [1:0]  cmdBank = '0;
  logic        rspValid;
  logic [31:0] rspData;
  logic        lmAddrValid;
  logic [11:0] lmAddr;

  int checks = 0;
  int fails  = 0;

  // reference model
  logic [31:0] mTag   [16];
  logic [3:0]  mState [16];
  int          order  [16];  // order[0] is least recent

  always #5 clk = ~clk;

  tag_cam u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdEntry(cmdEntry), .cmdData(cmdData), .cmdState(cmdState),
    .cmdLmEn(cmdLmEn), .cmdBank(cmdBank), .rspValid(rspValid),
    .rspData(rspData), .lmAddrValid(lmAddrValid), .lmAddr(lmAddr)
  );

  function automatic logic [31:0] poolVal(input int k);
    return (k + 1) * 32'h9E3779B1;
  endfunction

  function automatic void modelClear();
    for (int i = 0; i < 16; i++) begin
      mTag[i] = '0; mState[i] = '0; order[i] = i;
    end
  endfunction

  function automatic void modelTouch(input int e);
    int pos = 0;
    for (int i = 0; i < 16; i++) if (order[i] == e) pos = i;
    for (int i = pos; i < 15; i++) order[i] = order[i + 1];
    order[15] = e;
  endfunction

  function automatic int findTag(input logic [31:0] t);
    for (int i = 0; i < 16; i++) if (mTag[i] == t) return i;
    return -1;
  endfunction

  task automatic expect1(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic runCmd(input logic [2:0] op, input logic [3:0] ent,
                        input logic [31:0] dat, input logic [3:0] st,
                        input logic lmEn, input logic [1:0] bank, input string req);
    logic        expV, expLmV;
    logic [31:0] expD;
    logic [11:0] expLm;
    int          h;
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdEntry = ent; cmdData = dat;
    cmdState = st; cmdLmEn = lmEn; cmdBank = bank;
    expV = 1'b0; expLmV = 1'b0; expD = '0; expLm = '0;
    case (op)
      3'd0: begin
        expV = 1'b1;
        h = findTag(dat);
        if (h >= 0) begin
          expD = {20'd0, mState[h], 1'b1, 4'(h), 3'd0};
          modelTouch(h);
        end else begin
          expD = {20'd0, 4'd0, 1'b0, 4'(order[0]), 3'd0};
        end
        expLmV = lmEn;
        expLm  = {bank, expD[6:3], 6'd0};
      end
      3'd1: begin mTag[ent] = dat; mState[ent] = st; modelTouch(int'(ent)); end
      3'd2: mState[ent] = st;
      3'd3: begin expV = 1'b1; expD = mTag[ent]; end
      3'd4: begin expV = 1'b1; expD = {20'd0, mState[ent], 8'd0}; end
      3'd5: modelClear();
      default: ;
    endcase
    @(negedge clk);
    cmdValid = 1'b0; cmdLmEn = 1'b0;
    expect1(req, "rspValid", 32'(rspValid), 32'(expV));
    if (expV) expect1(req, "rspData", rspData, expD);
    expect1(req, "lmAddrValid", 32'(lmAddrValid), 32'(expLmV));
    if (expLmV) expect1(req, "lmAddr", 32'(lmAddr), 32'(expLm));
  endtask

  task automatic lookupTag(input logic [31:0] t, input logic lmEn, input logic [1:0] bank);
    runCmd(3'd0, 4'd0, t, 4'd0, lmEn, bank, (findTag(t) >= 0) ? "R4" : "R3");
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R10 reset state of the response outputs
    expect1("R10", "rspValid at reset", 32'(rspValid), 32'd0);
    expect1("R10", "rspData at reset", rspData, 32'd0);
    expect1("R10", "lmAddrValid at reset", 32'(lmAddrValid), 32'd0);
    expect1("R10", "lmAddr at reset", 32'(lmAddr), 32'd0);
    rstN = 1'b1;

    // R8 wipe, then reads and a miss pointing at slot 0
    runCmd(3'd5, 4'd0, 32'd0, 4'd0, 1'b0, 2'd0, "R8");
    runCmd(3'd3, 4'd5, 32'd0, 4'd0, 1'b0, 2'd0, "R8");
    runCmd(3'd4, 4'd9, 32'd0, 4'd0, 1'b0, 2'd0, "R8");
    lookupTag(poolVal(100), 1'b0, 2'd0);

    // R1 fill every slot
    for (int i = 0; i < 16; i++)
      runCmd(3'd1, 4'(i), poolVal(200 + i), 4'(i), 1'b0, 2'd0, "R1");
    runCmd(3'd3, 4'd7, 32'd0, 4'd0, 1'b0, 2'd0, "R1");
    runCmd(3'd4, 4'd7, 32'd0, 4'd0, 1'b0, 2'd0, "R1");

    // R5 miss keeps order, hit promotes
    lookupTag(poolVal(101), 1'b0, 2'd0);
    lookupTag(poolVal(101), 1'b0, 2'd0);
    lookupTag(poolVal(200), 1'b0, 2'd0);
    lookupTag(poolVal(101), 1'b0, 2'd0);  // R5 now slot 1

    // R6 state-only write keeps tag and order
    runCmd(3'd2, 4'd1, 32'd0, 4'hA, 1'b0, 2'd0, "R6");
    runCmd(3'd3, 4'd1, 32'd0, 4'd0, 1'b0, 2'd0, "R6");
    runCmd(3'd4, 4'd1, 32'd0, 4'd0, 1'b0, 2'd0, "R6");
    lookupTag(poolVal(102), 1'b0, 2'd0);  // R6 still slot 1

    // R7 readbacks leave order
    runCmd(3'd3, 4'd1, 32'd0, 4'd0, 1'b0, 2'd0, "R7");
    runCmd(3'd4, 4'd2, 32'd0, 4'd0, 1'b0, 2'd0, "R7");
    lookupTag(poolVal(103), 1'b0, 2'd0);  // R7 still slot 1

    // R9 address from hit and from miss
    lookupTag(poolVal(209), 1'b1, 2'd2);
    lookupTag(poolVal(104), 1'b1, 2'd3);

    // R10 reset keeps contents
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    expect1("R10", "rspValid in reset", 32'(rspValid), 32'd0);
    expect1("R10", "rspData in reset", rspData, 32'd0);
    rstN = 1'b1;
    runCmd(3'd3, 4'd3, 32'd0, 4'd0, 1'b0, 2'd0, "R10");
    lookupTag(poolVal(105), 1'b0, 2'd0);

    // mixed random traffic
    for (int n = 0; n < 800; n++) begin
      int          sel = int'($urandom % 32);
      logic [3:0]  ent = 4'($urandom);
      logic [3:0]  st  = 4'($urandom);
      logic [31:0] t   = poolVal(int'($urandom % 40));
      if (sel == 0) begin
        runCmd(3'd5, 4'd0, 32'd0, 4'd0, 1'b0, 2'd0, "R8");
      end else if (sel < 14) begin
        if (sel[0] && mTag[ent] != 32'd0) t = mTag[ent];
        lookupTag(t, 1'($urandom), 2'($urandom));
      end else if (sel < 20) begin
        int h = findTag(t);
        if (h >= 0 && h != int'(ent))
          runCmd(3'd2, ent, 32'd0, st, 1'b0, 2'd0, "R6");
        else
          runCmd(3'd1, ent, t, st, 1'b0, 2'd0, "R1");
      end else if (sel < 24) begin
        runCmd(3'd2, ent, 32'd0, st, 1'b0, 2'd0, "R6");
      end else if (sel < 28) begin
        runCmd(3'd3, ent, 32'd0, 4'd0, 1'b0, 2'd0, "R7");
      end else begin
        runCmd(3'd4, ent, 32'd0, 4'd0, 1'b0, 2'd0, "R7");
      end
    end

    runCmd(3'd5, 4'd0, 32'd0, 4'd0, 1'b0, 2'd0, "R8");
    lookupTag(poolVal(106), 1'b1, 2'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule